// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's-complement operands over several clocks. It examines one multiplier bit pair per clock and uses a single adder of XW+1 bits. A start strobe captures an XW-bit multiplicand and a YW-bit multiplier. The block then runs exactly YW add-or-subtract-then-shift steps on a working register. At the end it presents the signed (XW+YW)-bit product together with a single-cycle done pulse.

The working register and the stored multiplicand constants carry one guard bit above the upper field. This lets the negation of the most negative multiplicand be represented, so every operand pair, including that one, gives an exact product. Use the block where logic area matters more than latency. Pulse start while the block is idle, wait for done, then read the product. The product stays valid until the next multiplication completes.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset, done_o is 0 and product_o is all zeros.
- R2: For any signed operands, product_o after done_o equals the exact two's-complement product mcand_i × mplier_i over XW+YW bits (operands taken at the clock edge where start_i is accepted).
- R3: done_o goes high exactly YW clock edges after the edge that accepts start_i.
- R4: done_o is high for exactly one clock per multiplication.
- R5: start_i and new operand values presented while a multiplication is in progress, including its final step cycle, are ignored: result and timing are those of the running operation.
- R6: The most negative multiplicand is exact with any multiplier: with 4-bit operands, -8×2 gives 8'hF0, -8×-8 gives 8'h40, -8×-1 gives 8'h08, and -8×0 gives 0.
- R7: product_o keeps its value from one done pulse until the next done pulse, including the cycles of a multiplication in progress.
- R8: Each step recodes the lowest two bits of the working register: 01 adds the multiplicand, 10 subtracts it, and 00 or 11 add nothing. With 4-bit operands, 3×-4 gives 8'hF4, and multipliers made of long runs of ones or alternating bits give exact results.
- R9: A start_i presented in the cycle when done_o is high is accepted, so back-to-back operations need no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiplication (accepted only when idle) |
| mcand_i | input | XW | Signed multiplicand |
| mplier_i | input | YW | Signed multiplier |
| done_o | output | 1 | One-cycle pulse: product_o just updated |
| product_o | output | XW+YW | Signed product of the last completed operation |

## Verification
Two events can share a cycle: a start request and the final step of the current operation, or its completion. The bench raises start with new operands in the last step cycle and expects the request to be dropped, with the old result and timing intact. It also raises start in the cycle when done is high and expects that request to be accepted, with its own product after another YW edges. Both results are judged against a behavioural signed multiply, and the latency is counted in edges.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic [1:0] pair_i,
  output booth_op_e  op_o
);
  always_comb begin
    unique case (pair_i)
      2'b01:   op_o = OP_ADD;
      2'b10:   op_o = OP_SUB;
      default: op_o = OP_NONE;
    endcase
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int unsigned YW = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(YW + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign load_o = !busy_q && start_i;
  assign step_o = busy_q;
  assign last_o = busy_q && (cnt_q == CW'(1));
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(YW);
      end else if (busy_q) begin
        cnt_q <= cnt_q - CW'(1);
        if (last_o) busy_q <= 1'b0;
      end
    end
  end

  // R4: completion is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R5: a request during a running operation does not restart the count
  p_start_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && cnt_q > CW'(1)) |=> (busy_q && cnt_q == $past(cnt_q) - CW'(1)));

  // R3: an accepted start leads to a full count of steps
  p_full_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (cnt_q == CW'(YW)));
endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int unsigned XW = 8,
  parameter int unsigned YW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [XW-1:0]   mcand_i,
  input  logic [YW-1:0]   mplier_i,
  output logic [XW+YW-1:0] next_prod_o
);
  localparam int unsigned HW = XW + 1;      // guard + upper field
  localparam int unsigned PW = HW + YW + 1; // + multiplier + appended bit

  logic [HW-1:0] add_q, sub_q;  // upper parts of the add/subtract constants
  logic [PW-1:0] p_q, p_next;
  logic [HW-1:0] hi_sum, addend;
  booth_op_e     op;

  booth_recode u_recode (
    .pair_i (p_q[1:0]),
    .op_o   (op)
  );

  always_comb begin
    unique case (op)
      OP_ADD:  addend = add_q;
      OP_SUB:  addend = sub_q;
      default: addend = '0;
    endcase
    hi_sum = p_q[PW-1 -: HW] + addend;
    p_next = {hi_sum[HW-1], hi_sum, p_q[YW:1]};
  end

  assign next_prod_o = p_next[PW-2:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      add_q <= '0;
      sub_q <= '0;
      p_q   <= '0;
    end else if (load_i) begin
      add_q <= {mcand_i[XW-1], mcand_i};
      sub_q <= HW'(0) - {mcand_i[XW-1], mcand_i};
      p_q   <= {{HW{1'b0}}, mplier_i, 1'b0};
    end else if (step_i) begin
      p_q <= p_next;
    end
  end

  // R6: guard bit always mirrors the sign of the upper field
  p_guard_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_q[PW-1] == p_q[PW-2]);

  // R8: constants are negatives of each other while stepping
  p_const_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (HW'(add_q + sub_q) == '0));

  // R5: working register frozen when neither loading nor stepping
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(p_q));
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
  parameter int unsigned XW = 8,
  parameter int unsigned YW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [XW-1:0]    mcand_i,
  input  logic [YW-1:0]    mplier_i,
  output logic             done_o,
  output logic [XW+YW-1:0] product_o
);
  localparam int unsigned RW = XW + YW;

  logic          load, step, last;
  logic [RW-1:0] next_prod;
  logic [RW-1:0] result_q;

  booth_ctrl #(.YW(YW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .done_o  (done_o)
  );

  booth_datapath #(.XW(XW), .YW(YW)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .step_i      (step),
    .mcand_i     (mcand_i),
    .mplier_i    (mplier_i),
    .next_prod_o (next_prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   result_q <= '0;
    else if (last) result_q <= next_prod;
  end

  assign product_o = result_q;

  // R7: product only moves together with a done pulse
  p_result_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(product_o) |-> done_o);
endmodule

// File: tb/tb_booth_seq_mul.sv
module tb_booth_seq_mul;
  localparam int XW = 4;
  localparam int YW = 4;
  localparam int NV = 12;
  // {mcand, mplier, expected product}
  localparam logic [15:0] VEC [NV] = '{
    16'h82F0, 16'h3CF4, 16'h8840, 16'h8000, 16'h8F08, 16'h78C8,
    16'hFF01, 16'h7731, 16'h651E, 16'hDA12, 16'h0800, 16'h18F8
  };

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [XW-1:0] ma = '0;
  logic [YW-1:0] mb = '0;
  logic done;
  logic [XW+YW-1:0] prod;
  int errors = 0, checks = 0;
  bit fin = 1'b0;

  always #4 clk = ~clk;

  booth_seq_mul #(.XW(XW), .YW(YW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .mcand_i(ma), .mplier_i(mb), .done_o(done), .product_o(prod)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_mul(input logic [3:0] a, input logic [3:0] b);
    int r;
    r = int'($signed(a)) * int'($signed(b));
    return r[7:0];
  endfunction

  task automatic run_mul(input logic [3:0] a, input logic [3:0] b,
                         output logic [7:0] p, output int lat);
    @(negedge clk);
    start = 1'b1; ma = a; mb = b;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    p = prod;
  endtask

  task automatic finish_run();
    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    logic [7:0] p;
    int lat;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(prod == '0, "R1 product", int'(prod), 0);

    // vector table: R2, R6, R8
    for (int i = 0; i < NV; i++) begin
      run_mul(VEC[i][15:12], VEC[i][11:8], p, lat);
      chk(p == VEC[i][7:0], "R2/R6/R8 vector", int'(p), int'(VEC[i][7:0]));
      chk(lat == YW, "R3 latency", lat, YW);
      @(negedge clk);
      chk(done == 1'b0, "R4 single pulse", int'(done), 0);
    end

    // exhaustive sweep: R2
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run_mul(4'(a), 4'(b), p, lat);
        chk(p == ref_mul(4'(a), 4'(b)), "R2 sweep", int'(p), int'(ref_mul(4'(a), 4'(b))));
      end
    end

    // R5: start in middle and in final step cycle is ignored; R9 start in done cycle accepted
    @(negedge clk);
    start = 1'b1; ma = 4'd3; mb = 4'd3;
    @(negedge clk);                 // after capture edge
    start = 1'b1; ma = 4'd7; mb = 4'd7;
    @(negedge clk);                 // after step 1
    start = 1'b0;
    @(negedge clk);                 // after step 2
    @(negedge clk);                 // after step 3, final step next
    start = 1'b1; ma = 4'h8; mb = 4'h8;
    @(negedge clk);                 // after step 4: done
    chk(done == 1'b1, "R5 timing kept", int'(done), 1);
    chk(prod == 8'd9, "R5 ignored start", int'(prod), 9);
    start = 1'b1; ma = 4'h9; mb = 4'h2;  // R9: accepted here
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R4 pulse end", int'(done), 0);
    chk(prod == 8'd9, "R7 hold during run", int'(prod), 9);
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == YW, "R9 back-to-back latency", lat, YW);
    chk(prod == ref_mul(4'h9, 4'h2), "R9 back-to-back product", int'(prod),
        int'(ref_mul(4'h9, 4'h2)));

    // R7: held while idle with changing inputs
    ma = 4'h5; mb = 4'h5;
    repeat (6) @(negedge clk);
    chk(prod == ref_mul(4'h9, 4'h2), "R7 hold idle", int'(prod), int'(ref_mul(4'h9, 4'h2)));
    chk(done == 1'b0, "R4 no spurious done", int'(done), 0);

    // R6: most negative squared directly
    run_mul(4'h8, 4'h8, p, lat);
    chk(p == 8'h40, "R6 min squared", int'(p), 64);

    finish_run();
  end
endmodule